// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block holds the processor's 32-bit current status word and carries out the two control-flow events that change privilege: taking an exception and returning from one. Each cycle it looks at seven exception request lines, a return request, the return address offered by the fetch logic, a vector-base select, and the saved status word and link value read back from the banked register file. It then produces a registered update. An update can be a new PC with a load strobe, a new status word, and write strobes with data aimed at the saved-status and link registers of the mode being entered.

When several requests arrive in the same cycle, a fixed priority picks one. An IRQ or FIQ request whose mask bit is set in the current status word is disregarded. A taken exception saves the old status word and the return address into the target mode's bank and switches to that mode. It also forces the 32-bit instruction state, masks interrupts and jumps to that exception's vector. A return copies the saved status word back and reloads the PC from the link value. Each event completes in a single clock, and a one-cycle completion pulse marks it.

Top module: `exc_seq`

## Requirements
- R1: After reset the status word reads 0x000000D3 (supervisor mode, both interrupt masks set, 32-bit state), and done, pc_load and both write strobes are low.
- R2: One cycle after an exception is accepted, sv_we is high, sv_wdata equals the status word held before entry, and bank_mode gives the mode being entered.
- R3: In the same cycle as R2, lr_we is high and lr_wdata equals the ret_addr value that was presented with the request.
- R4: In the same cycle as R2, pc_load is high and pc equals base plus offset. The base is 0x00000000 when hivec is 0 and 0xFFFF0000 when it is 1. The offsets are reset 0x00, undefined 0x04, software call 0x08, fetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R5: The mode field (status bits 4:0) after entry is 10011 for reset and software call, 11011 for undefined, 10111 for either abort, 10010 for IRQ and 10001 for FIQ. The request bits of exc_req are 0 reset, 1 undefined, 2 software call, 3 fetch abort, 4 data abort, 5 IRQ, 6 FIQ.
- R6: On entry, status bit 5 (T) is cleared and bit 7 (I) is set. Bit 6 (F) is set for reset and FIQ and otherwise kept. Bits 31:8, which include the flags N Z C V in 31:28, are kept.
- R7: Simultaneous requests resolve in this order, highest first: reset, data abort, FIQ, IRQ, fetch abort, undefined, software call.
- R8: An IRQ request is ignored while status bit 7 is 1, and an FIQ request is ignored while status bit 6 is 1. A lower-priority request that is present in the same cycle is served instead.
- R9: A return request loads status from sv_rdata and pc from lr_rdata one cycle later, with pc_load and done high and both write strobes low.
- R10: A return request is ignored in user mode (10000) and system mode (11111). It is also ignored when any exception is accepted in the same cycle.
- R11: done and pc_load are high for exactly the one cycle following each accepted event, and they are low in a cycle that follows no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 7 | Exception request lines, bit order as in R5 |
| ret_req | input | 1 | Return-from-exception request |
| ret_addr | input | 32 | Return address to be saved on entry |
| hivec | input | 1 | Selects the high vector base |
| sv_rdata | input | 32 | Saved status word of the current mode |
| lr_rdata | input | 32 | Link value of the current mode |
| status | output | 32 | Current status word |
| pc | output | 32 | New program counter |
| pc_load | output | 1 | pc is valid this cycle |
| sv_we | output | 1 | Write strobe for the banked saved status word |
| sv_wdata | output | 32 | Data for the saved status word |
| lr_we | output | 1 | Write strobe for the banked link register |
| lr_wdata | output | 32 | Data for the link register |
| bank_mode | output | 5 | Mode whose bank the strobes address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach is one where the interrupt masks are clear. Reset leaves both masks set, and no entry ever clears them, so IRQ and FIQ entries cannot be tested straight after reset. The stimulus reaches these states only by issuing returns with crafted saved status words: one for user mode with the masks clear, and one for system mode with the masks clear. From system mode, every priority pair and the masked-IRQ fall-through are then tested. Before each new priority case, a further crafted return brings the controller back to system mode.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN    = 32;
    localparam int NUM_EXC = 7;
    localparam int MODE_W  = 5;

    // request line indices
    localparam int EX_RESET = 0;
    localparam int EX_UND   = 1;
    localparam int EX_SWI   = 2;
    localparam int EX_PABT  = 3;
    localparam int EX_DABT  = 4;
    localparam int EX_IRQ   = 5;
    localparam int EX_FIQ   = 6;

    // status word bit positions
    localparam int BIT_T = 5;
    localparam int BIT_F = 6;
    localparam int BIT_I = 7;

    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    localparam logic [XLEN-1:0] RESET_STATUS = 32'h0000_00D3;

    // highest priority first
    localparam int PRIO_ORDER [NUM_EXC] = '{EX_RESET, EX_DABT, EX_FIQ, EX_IRQ,
                                            EX_PABT, EX_UND, EX_SWI};

    function automatic logic [MODE_W-1:0] exc_mode(input int k);
        case (k)
            EX_UND:           return MODE_UND;
            EX_PABT, EX_DABT: return MODE_ABT;
            EX_IRQ:           return MODE_IRQ;
            EX_FIQ:           return MODE_FIQ;
            default:          return MODE_SVC;
        endcase
    endfunction

    // slot 0x14 is unused, so IRQ and FIQ sit one word further up
    function automatic logic [7:0] exc_offset(input int k);
        int slot;
        slot = (k >= EX_IRQ) ? k + 1 : k;
        return 8'(slot * 4);
    endfunction

    typedef struct packed {
        logic [XLEN-1:0]   status;
        logic [XLEN-1:0]   pc;
        logic [XLEN-1:0]   sv_wdata;
        logic [XLEN-1:0]   lr_wdata;
        logic [MODE_W-1:0] bank_mode;
        logic              sv_we;
        logic              lr_we;
        logic              pc_load;
        logic              done;
    } seq_state_t;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic [NUM_EXC-1:0] req,
    input  logic               irq_mask,
    input  logic               fiq_mask,
    output logic [NUM_EXC-1:0] grant,
    output logic               any
);

    logic [NUM_EXC-1:0] live;

    always_comb begin
        live         = req;
        live[EX_IRQ] = req[EX_IRQ] & ~irq_mask;
        live[EX_FIQ] = req[EX_FIQ] & ~fiq_mask;
    end

    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int p = 0; p < NUM_EXC; p++) begin
            if (!any && live[PRIO_ORDER[p]]) begin
                grant[PRIO_ORDER[p]] = 1'b1;
                any                  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter logic [XLEN-1:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  logic [NUM_EXC-1:0] grant,
    input  logic               hivec,
    output logic [XLEN-1:0]    vector,
    output logic [MODE_W-1:0]  mode,
    output logic               set_f
);

    logic [7:0]        off_part  [NUM_EXC];
    logic [MODE_W-1:0] mode_part [NUM_EXC];

    for (genvar k = 0; k < NUM_EXC; k++) begin : g_kind
        assign off_part[k]  = grant[k] ? exc_offset(k) : 8'h00;
        assign mode_part[k] = grant[k] ? exc_mode(k)   : '0;
    end

    always_comb begin
        logic [7:0] off;
        off  = 8'h00;
        mode = '0;
        for (int k = 0; k < NUM_EXC; k++) begin
            off  = off  | off_part[k];
            mode = mode | mode_part[k];
        end
        vector = (hivec ? HIGH_BASE : '0) | {{(XLEN-8){1'b0}}, off};
    end

    assign set_f = grant[EX_RESET] | grant[EX_FIQ];

endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_pkg::*;
#(
    parameter logic [31:0] HIGH_BASE = 32'hFFFF_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  exc_req,
    input  logic        ret_req,
    input  logic [31:0] ret_addr,
    input  logic        hivec,
    input  logic [31:0] sv_rdata,
    input  logic [31:0] lr_rdata,
    output logic [31:0] status,
    output logic [31:0] pc,
    output logic        pc_load,
    output logic        sv_we,
    output logic [31:0] sv_wdata,
    output logic        lr_we,
    output logic [31:0] lr_wdata,
    output logic [4:0]  bank_mode,
    output logic        done
);

    seq_state_t st_q, st_d;

    logic [NUM_EXC-1:0] grant;
    logic               take;
    logic [XLEN-1:0]    vec;
    logic [MODE_W-1:0]  tgt_mode;
    logic               tgt_set_f;
    logic               has_saved;

    exc_arbiter u_arb (
        .req      (exc_req),
        .irq_mask (st_q.status[BIT_I]),
        .fiq_mask (st_q.status[BIT_F]),
        .grant    (grant),
        .any      (take)
    );

    exc_vector #(.HIGH_BASE(HIGH_BASE)) u_vec (
        .grant  (grant),
        .hivec  (hivec),
        .vector (vec),
        .mode   (tgt_mode),
        .set_f  (tgt_set_f)
    );

    assign has_saved = (st_q.status[4:0] != MODE_USR) && (st_q.status[4:0] != MODE_SYS);

    always_comb begin
        st_d         = st_q;
        st_d.sv_we   = 1'b0;
        st_d.lr_we   = 1'b0;
        st_d.pc_load = 1'b0;
        st_d.done    = 1'b0;
        if (take) begin
            st_d.status[4:0]   = tgt_mode;
            st_d.status[BIT_T] = 1'b0;
            st_d.status[BIT_I] = 1'b1;
            if (tgt_set_f)
                st_d.status[BIT_F] = 1'b1;
            st_d.sv_wdata  = st_q.status;
            st_d.lr_wdata  = ret_addr;
            st_d.bank_mode = tgt_mode;
            st_d.pc        = vec;
            st_d.sv_we     = 1'b1;
            st_d.lr_we     = 1'b1;
            st_d.pc_load   = 1'b1;
            st_d.done      = 1'b1;
        end else if (ret_req && has_saved) begin
            st_d.status  = sv_rdata;
            st_d.pc      = lr_rdata;
            st_d.pc_load = 1'b1;
            st_d.done    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.status    <= RESET_STATUS;
            st_q.bank_mode <= MODE_SVC;
        end else begin
            st_q <= st_d;
        end
    end

    assign status    = st_q.status;
    assign pc        = st_q.pc;
    assign pc_load   = st_q.pc_load;
    assign sv_we     = st_q.sv_we;
    assign sv_wdata  = st_q.sv_wdata;
    assign lr_we     = st_q.lr_we;
    assign lr_wdata  = st_q.lr_wdata;
    assign bank_mode = st_q.bank_mode;
    assign done      = st_q.done;

    // R6
    entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sv_we |-> (!status[BIT_T] && status[BIT_I] && status[4:0] == bank_mode));

    // R2
    entry_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sv_we |-> (lr_we && pc_load && done));

    // R2
    saved_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sv_we |-> (sv_wdata == $past(status)));

    // R9
    return_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sv_we) |-> (status == $past(sv_rdata) && pc == $past(lr_rdata)));

    // R10
    return_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sv_we) |-> ($past(status[4:0]) != MODE_USR && $past(status[4:0]) != MODE_SYS));

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sv_we && bank_mode == MODE_IRQ) |-> !$past(status[BIT_I]));

endmodule

// File: tb/exc_seq_test.sv
module exc_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  exc_req = '0;
    logic        ret_req = 1'b0;
    logic [31:0] ret_addr = '0;
    logic        hivec = 1'b0;
    logic [31:0] sv_rdata = '0;
    logic [31:0] lr_rdata = '0;
    logic [31:0] status, pc, sv_wdata, lr_wdata;
    logic        pc_load, sv_we, lr_we, done;
    logic [4:0]  bank_mode;

    always #5 clk = ~clk;

    exc_seq uut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .ret_req(ret_req),
        .ret_addr(ret_addr), .hivec(hivec), .sv_rdata(sv_rdata), .lr_rdata(lr_rdata),
        .status(status), .pc(pc), .pc_load(pc_load), .sv_we(sv_we),
        .sv_wdata(sv_wdata), .lr_we(lr_we), .lr_wdata(lr_wdata),
        .bank_mode(bank_mode), .done(done)
    );

    localparam logic [6:0] Q_RST = 7'h01, Q_UND = 7'h02, Q_SWI = 7'h04, Q_PABT = 7'h08,
                           Q_DABT = 7'h10, Q_IRQ = 7'h20, Q_FIQ = 7'h40;

    typedef struct {
        logic [31:0] status, pc, sv_wdata, lr_wdata;
        logic [4:0]  bank_mode;
        logic        pc_load, sv_we, lr_we, done;
        string       tag;
    } exp_t;

    exp_t        sb [$];
    logic [31:0] mstat = 32'h0000_00D3;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 0;

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // driver: drives one cycle of stimulus and queues what the outputs must show
    task automatic step(input logic [6:0] req, input logic ret, input logic [31:0] ra,
                        input logic hv, input logic [31:0] svr, input logic [31:0] lrr,
                        input string tag);
        exp_t e;
        logic [6:0] eff;
        int win;
        int ord [7] = '{0, 4, 6, 5, 3, 1, 2};
        @(negedge clk);
        exc_req = req; ret_req = ret; ret_addr = ra; hivec = hv;
        sv_rdata = svr; lr_rdata = lrr;
        eff = req;
        if (mstat[7]) eff[5] = 1'b0;
        if (mstat[6]) eff[6] = 1'b0;
        win = -1;
        for (int p = 0; p < 7; p++)
            if (win < 0 && eff[ord[p]]) win = ord[p];
        e = '{status: mstat, pc: '0, sv_wdata: '0, lr_wdata: '0, bank_mode: '0,
              pc_load: 1'b0, sv_we: 1'b0, lr_we: 1'b0, done: 1'b0, tag: tag};
        if (win >= 0) begin
            logic [4:0] m;
            logic [31:0] off;
            case (win)
                0: begin m = 5'b10011; off = 32'h00; end
                1: begin m = 5'b11011; off = 32'h04; end
                2: begin m = 5'b10011; off = 32'h08; end
                3: begin m = 5'b10111; off = 32'h0C; end
                4: begin m = 5'b10111; off = 32'h10; end
                5: begin m = 5'b10010; off = 32'h18; end
                default: begin m = 5'b10001; off = 32'h1C; end
            endcase
            e.status = {mstat[31:8], 1'b1, (win == 0 || win == 6) ? 1'b1 : mstat[6], 1'b0, m};
            e.pc = (hv ? 32'hFFFF_0000 : 32'h0) + off;
            e.sv_wdata = mstat; e.lr_wdata = ra; e.bank_mode = m;
            e.pc_load = 1; e.sv_we = 1; e.lr_we = 1; e.done = 1;
        end else if (ret && mstat[4:0] != 5'b10000 && mstat[4:0] != 5'b11111) begin
            e.status = svr; e.pc = lrr; e.pc_load = 1; e.done = 1;
        end
        mstat = e.status;
        sb.push_back(e);
    endtask

    // monitor: compares after each edge, away from it
    initial forever begin
        @(posedge clk);
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            bit ok;
            e = sb.pop_front();
            ok = (done == e.done) && (pc_load == e.pc_load) && (sv_we == e.sv_we) &&
                 (lr_we == e.lr_we) && (status == e.status);
            if (e.pc_load && pc !== e.pc) ok = 0;
            if (e.sv_we && (sv_wdata !== e.sv_wdata || bank_mode !== e.bank_mode)) ok = 0;
            if (e.lr_we && lr_wdata !== e.lr_wdata) ok = 0;
            n_checks++;
            if (!ok) begin
                n_fail++;
                $display("FAIL %s: got st=%h pc=%h ld=%b done=%b sw=%b/%h lw=%b/%h bm=%b ; exp st=%h pc=%h ld=%b done=%b sw=%b/%h lw=%b/%h bm=%b",
                         e.tag, status, pc, pc_load, done, sv_we, sv_wdata, lr_we, lr_wdata, bank_mode,
                         e.status, e.pc, e.pc_load, e.done, e.sv_we, e.sv_wdata, e.lr_we, e.lr_wdata, e.bank_mode);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    localparam logic [31:0] SYS_OPEN = 32'h0000_001F;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (status !== 32'h0000_00D3 || done || pc_load || sv_we || lr_we) begin
            n_fail++;
            $display("FAIL R1: got st=%h done=%b ld=%b sw=%b lw=%b expected st=000000d3 and all low",
                     status, done, pc_load, sv_we, lr_we);
        end
        step(Q_SWI, 0, 32'h0000_1004, 0, 0, 0, "R2 R3 R4 R5 software call from reset state");
        step(0, 0, 0, 0, 0, 0, "R11 idle after entry");
        step(0, 1, 0, 0, 32'h6000_0030, 32'h0000_1004, "R9 return to user mode");
        step(0, 1, 0, 0, 32'h0000_00D3, 32'h0000_5555, "R10 return ignored in user mode");
        step(Q_IRQ, 0, 32'h0000_2008, 1, 0, 0, "R4 R6 IRQ with high vectors");
        step(Q_IRQ, 0, 32'h0000_3000, 1, 0, 0, "R8 IRQ ignored while I set");
        step(Q_FIQ, 0, 32'h0000_3004, 1, 0, 0, "R5 R6 FIQ sets F");
        step(Q_FIQ, 0, 32'h0000_3008, 1, 0, 0, "R8 FIQ ignored while F set");
        step(0, 1, 0, 0, 32'h6000_0092, 32'h0000_3004, "R9 return FIQ to IRQ mode");
        step(0, 1, 0, 0, SYS_OPEN, 32'h0000_2008, "R9 return to system mode");
        step(0, 1, 0, 0, 32'h0000_00D3, 32'h0000_7777, "R10 return ignored in system mode");
        step(7'h7F, 0, 32'h0000_4000, 0, 0, 0, "R7 reset beats all");
        step(0, 1, 0, 0, SYS_OPEN, 32'h100, "R9 back to system");
        step(7'h7E, 0, 32'h0000_4100, 0, 0, 0, "R7 data abort beats FIQ");
        step(0, 1, 0, 0, SYS_OPEN, 32'h200, "R9 back to system");
        step(7'h6E, 0, 32'h0000_4200, 0, 0, 0, "R7 FIQ beats IRQ");
        step(0, 1, 0, 0, SYS_OPEN, 32'h300, "R9 back to system");
        step(Q_IRQ | Q_PABT | Q_UND, 0, 32'h0000_4300, 1, 0, 0, "R7 IRQ beats fetch abort");
        step(0, 1, 0, 0, SYS_OPEN, 32'h400, "R9 back to system");
        step(Q_PABT | Q_UND | Q_SWI, 0, 32'h0000_4400, 0, 0, 0, "R7 fetch abort beats undefined");
        step(Q_IRQ | Q_PABT, 0, 32'h0000_4480, 0, 0, 0, "R8 masked IRQ lets fetch abort through");
        step(0, 1, 0, 0, SYS_OPEN, 32'h500, "R9 back to system");
        step(Q_UND | Q_SWI, 0, 32'h0000_4500, 1, 0, 0, "R5 R7 undefined beats software call");
        step(Q_DABT, 1, 32'h0000_4600, 0, 32'h0000_001F, 32'h999, "R10 exception beats return");
        step(0, 0, 0, 0, 0, 0, "R11 idle no pulse");
        step(Q_RST, 0, 32'h0000_4700, 1, 0, 0, "R4 R6 reset with high vectors");
        step(0, 0, 0, 0, 0, 0, "R11 final idle");
        repeat (3) @(negedge clk);
        report();
    end

endmodule